// File: doc/BRIEF.md
# Byte-Wide Parallel Port Host Register Set

This block is the host-facing register bank of a legacy 8-bit parallel port. A simple CPU-style bus (address, read strobe, write strobe, byte write data, registered read data) reaches a data latch, a read-only status register, a control register and a mode register. The block drives the peripheral data pins from the data latch. It presents four control outputs taken from the control register, and it samples five status inputs.

Two operating modes matter. In compatible mode the data pins are always driven and a data read returns the latch. In extended mode, control bit 5 can turn the port around. When it is set, the pins are released and a data read returns the value seen on the pins. The other mode codes are stored and read back, but the data path treats them as compatible mode. All pin inputs pass through a two-flop synchronizer before they are read. The pin output enable is registered.

Top module: `lpt_host_regs`

## Requirements
- R1: The register map is: addr 0 data, addr 1 status, addr 2 control, addr 6 mode. Mode bits 7:5 are the mode code and bits 4:0 read as zero. Reads of addr 3, 4, 5 and 7 return 0x00. Read data appears on rdata_o one cycle after the read strobe and holds until the next read.
- R2: After reset: the data latch, the control register and the mode code are zero, pd_oe_o is 1, ctl_oe_o is 0, and rdata_o is 0x00.
- R3: A write to addr 0 loads the data latch, and pd_o shows it from the next cycle, in every mode.
- R4: In compatible mode (code 000), pd_oe_o stays 1 whatever control bit 5 holds, and a data read returns the latch.
- R5: In extended mode (code 001) with control bit 5 = 0, pd_oe_o is 1 and a data read returns the latch.
- R6: In extended mode with control bit 5 = 1, pd_oe_o is 0 and a data read returns pd_i after the two-flop synchronizer.
- R7: A status read returns {synchronized stat_i[4:0], 3'b000}. Writes to addr 1 have no effect.
- R8: A control read returns {2'b00, ctl[5:0]}, and ctl_o equals ctl[3:0].
- R9: ctl_oe_o is 0 from reset until the first control write. After that it stays 1 until the next reset.
- R10: pd_oe_o changes only in the cycle after the cycle in which a control or mode write was captured.
- R11: Mode codes other than 000 and 001 read back unchanged and behave as compatible mode: pins driven, data reads return the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Register address |
| rd_i | input | 1 | Read strobe, one cycle |
| wr_i | input | 1 | Write strobe, one cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| pd_o | output | 8 | Peripheral data out (data latch) |
| pd_oe_o | output | 1 | Peripheral data output enable |
| pd_i | input | 8 | Peripheral data pins in |
| ctl_o | output | 4 | Control outputs (strobe, autofeed, init, select-in) |
| ctl_oe_o | output | 1 | Control output enable |
| stat_i | input | 5 | Peripheral status inputs |

## Verification
The main target is the turnaround rule. Control bit 5 is set while in compatible mode, then the mode is switched to extended, then an out-of-scope code is selected. A design that ignored the mode would release the pins in compatible mode and return pin data instead of the latch. Pin and status values are changed between reads so that a missing or bypassed synchronizer, or a read mux picking the wrong source, shows up as the wrong byte. The bench samples pd_oe_o in the cycle right after a control write and again one cycle later, which catches an enable that is unregistered or lags by two cycles. It also writes the status address and clears the control register to show that status is read-only and that the control enable does not fall again.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int AW      = 3;
  localparam int DW      = 8;
  localparam int CW      = 6;
  localparam int STW     = 5;
  localparam int DIR_BIT = 5;

  localparam logic [AW-1:0] OFS_DATA = 3'd0;
  localparam logic [AW-1:0] OFS_STAT = 3'd1;
  localparam logic [AW-1:0] OFS_CTRL = 3'd2;
  localparam logic [AW-1:0] OFS_MODE = 3'd6;

  typedef enum logic [2:0] {
    MODE_COMPAT = 3'b000,
    MODE_EXT    = 3'b001,
    MODE_FIFO   = 3'b010,
    MODE_ECP    = 3'b011,
    MODE_EPP    = 3'b100
  } lpt_mode_e;
endpackage

// File: rtl/lpt_sync.sv
module lpt_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lpt_regs.sv
module lpt_regs
  import lpt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] ctl_o,
  output logic [2:0]    mode_o,
  output logic          cfg_done_o
);
  logic [DW-1:0] data_q;
  logic [CW-1:0] ctl_q;
  logic [2:0]    mode_q;
  logic          cfg_done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q     <= '0;
      ctl_q      <= '0;
      mode_q     <= MODE_COMPAT;
      cfg_done_q <= 1'b0;
    end else if (wr_i) begin
      case (addr_i)
        OFS_DATA: data_q <= wdata_i;
        OFS_CTRL: begin
          ctl_q      <= wdata_i[CW-1:0];
          cfg_done_q <= 1'b1;
        end
        OFS_MODE: mode_q <= wdata_i[DW-1:DW-3];
        default: ;  // status and unused offsets ignore writes
      endcase
    end
  end

  // R9
  cfg_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(cfg_done_q));

  // R3
  data_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_DATA) |=> (data_q == $past(wdata_i)));

  assign data_o     = data_q;
  assign ctl_o      = ctl_q;
  assign mode_o     = mode_q;
  assign cfg_done_o = cfg_done_q;
endmodule

// File: rtl/lpt_host_regs.sv
module lpt_host_regs
  import lpt_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [AW-1:0]  addr_i,
  input  logic           rd_i,
  input  logic           wr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  output logic [DW-1:0]  pd_o,
  output logic           pd_oe_o,
  input  logic [DW-1:0]  pd_i,
  output logic [3:0]     ctl_o,
  output logic           ctl_oe_o,
  input  logic [STW-1:0] stat_i
);
  localparam int SYNC_STAGES = 2;

  logic [DW-1:0]  data_q, pd_sync;
  logic [CW-1:0]  ctl_q;
  logic [2:0]     mode_q;
  logic           cfg_done;
  logic [STW-1:0] stat_sync;
  logic           ext_q, turn_in;
  logic           pd_oe_q;
  logic [DW-1:0]  rd_mux, rdata_q;

  lpt_regs u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_i, .wdata_i,
    .data_o(data_q), .ctl_o(ctl_q), .mode_o(mode_q), .cfg_done_o(cfg_done)
  );

  lpt_sync #(.W(DW), .STAGES(SYNC_STAGES)) u_pd_sync (
    .clk_i, .rst_ni, .d_i(pd_i), .q_o(pd_sync)
  );

  lpt_sync #(.W(STW), .STAGES(SYNC_STAGES)) u_st_sync (
    .clk_i, .rst_ni, .d_i(stat_i), .q_o(stat_sync)
  );

  assign ext_q   = (mode_q == MODE_EXT);
  assign turn_in = ext_q && ctl_q[DIR_BIT];

  // enable follows register state one cycle later
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) pd_oe_q <= 1'b1;
    else         pd_oe_q <= !turn_in;

  always_comb begin
    case (addr_i)
      OFS_DATA: rd_mux = turn_in ? pd_sync : data_q;
      OFS_STAT: rd_mux = {stat_sync, {(DW-STW){1'b0}}};
      OFS_CTRL: rd_mux = {{(DW-CW){1'b0}}, ctl_q};
      OFS_MODE: rd_mux = {mode_q, {(DW-3){1'b0}}};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;

  // R4
  compat_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_q |=> pd_oe_q);

  // R6
  ext_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_q && ctl_q[DIR_BIT]) |=> !pd_oe_q);

  // R10
  oe_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pd_oe_q) |-> $past(wr_i, 2));

  // R1
  unused_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (addr_i == 3'd3 || addr_i == 3'd7)) |=> (rdata_q == '0));

  assign rdata_o  = rdata_q;
  assign pd_o     = data_q;
  assign pd_oe_o  = pd_oe_q;
  assign ctl_o    = ctl_q[3:0];
  assign ctl_oe_o = cfg_done;
endmodule

// File: tb/lpt_host_regs_tb_top.sv
module lpt_host_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] addr_i = '0;
  logic       rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0] wdata_i = '0, pd_i = '0;
  logic [4:0] stat_i = '0;
  logic [7:0] rdata_o, pd_o;
  logic [3:0] ctl_o;
  logic       pd_oe_o, ctl_oe_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic rd_d = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;  // 125 MHz

  lpt_host_regs dut_i (
    .clk_i(clk), .rst_ni, .addr_i, .rd_i, .wr_i, .wdata_i, .rdata_o,
    .pd_o, .pd_oe_o, .pd_i, .ctl_o, .ctl_oe_o, .stat_i
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk); wr_i = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] exp, string tag);
    @(negedge clk); addr_i = a; rd_i = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd_i = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) rd_d <= rd_i;

  // monitor: compare the registered read data against the scoreboard
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 8'h00, 8'hFF);
      else check(tag_q.pop_front(), rdata_o, exp_q.pop_front());
    end
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    check("R2 rdata", rdata_o, 8'h00);
    check("R2 pd_oe", {7'd0, pd_oe_o}, 8'h01);
    check("R2 ctl_oe", {7'd0, ctl_oe_o}, 8'h00);
    check("R2 pd_o", pd_o, 8'h00);
    rd(3'd0, 8'h00, "R2 data");
    rd(3'd2, 8'h00, "R2 ctrl");
    rd(3'd6, 8'h00, "R2 mode");

    wr(3'd0, 8'hA5);
    check("R3 pd_o", pd_o, 8'hA5);
    rd(3'd0, 8'hA5, "R4 data read compat");

    pd_i = 8'h3C;
    wr(3'd2, 8'h2B);
    check("R9 ctl_oe after write", {7'd0, ctl_oe_o}, 8'h01);
    check("R8 ctl_o", {4'd0, ctl_o}, 8'h0B);
    idle(2);
    check("R4 pd_oe compat dir=1", {7'd0, pd_oe_o}, 8'h01);
    rd(3'd2, 8'h2B, "R8 ctrl read");
    rd(3'd0, 8'hA5, "R4 latch despite dir=1");
    rd(3'd3, 8'h00, "R1 addr3");
    rd(3'd5, 8'h00, "R1 addr5");

    stat_i = 5'b10110;
    idle(4);
    rd(3'd1, 8'hB0, "R7 status");
    wr(3'd1, 8'hFF);
    rd(3'd1, 8'hB0, "R7 status after write");
    rd(3'd0, 8'hA5, "R7 data untouched");

    wr(3'd6, 8'h3F);
    check("R10 pd_oe not yet", {7'd0, pd_oe_o}, 8'h01);
    idle(1);
    check("R6 pd_oe released", {7'd0, pd_oe_o}, 8'h00);
    rd(3'd0, 8'h3C, "R6 pin read");
    rd(3'd6, 8'h20, "R1 mode read");
    pd_i = 8'h81;
    idle(4);
    rd(3'd0, 8'h81, "R6 pin read 2");
    wr(3'd0, 8'h5A);
    check("R3 pd_o ext in", pd_o, 8'h5A);
    rd(3'd0, 8'h81, "R6 pins not latch");

    wr(3'd2, 8'h0B);
    check("R10 pd_oe holds", {7'd0, pd_oe_o}, 8'h00);
    idle(1);
    check("R5 pd_oe driven", {7'd0, pd_oe_o}, 8'h01);
    rd(3'd0, 8'h5A, "R5 latch read");
    idle(3);
    check("R10 pd_oe stable", {7'd0, pd_oe_o}, 8'h01);

    wr(3'd2, 8'h2B);
    idle(1);
    check("R6 pd_oe again", {7'd0, pd_oe_o}, 8'h00);
    wr(3'd6, 8'h60);
    idle(1);
    check("R11 ecp drives", {7'd0, pd_oe_o}, 8'h01);
    rd(3'd0, 8'h5A, "R11 ecp latch");
    rd(3'd6, 8'h60, "R11 mode readback");
    wr(3'd6, 8'h80);
    idle(1);
    check("R11 epp drives", {7'd0, pd_oe_o}, 8'h01);
    rd(3'd0, 8'h5A, "R11 epp latch");

    wr(3'd2, 8'h00);
    idle(2);
    check("R9 ctl_oe sticky", {7'd0, ctl_oe_o}, 8'h01);
    check("R8 ctl_o cleared", {4'd0, ctl_o}, 8'h00);
    idle(2);
    check("scoreboard drained", 8'(exp_q.size()), 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule